// File: doc/BRIEF.md
# Dual-Pixel Video Stream Formatter

This block turns pixel samples from two converter channels into a parallel camera output word. Every pixel clock cycle carries two pixels side by side, together with a frame-valid flag and a line-valid flag. A receiver treats the pixel fields as meaningful only while both flags are high. A runtime mode input selects full 10-bit pixels or a reduced 8-bit form. The reduced form discards the two least significant bits of each sample and fills the unused upper bits with zero.

Software-set inputs give the line width in pixels, the frame height in lines, the gap between lines and the gap after a frame. A start pulse tells the block that acquisition of a frame has finished, and the frame then streams out line by line. For bring-up, an internal counter pattern can stand in for the converter samples. The sequencing logic runs on the rising clock edge. The output word is launched on the falling edge.

Top module: `dual_pixel_formatter`

## Requirements
- R1: While in reset, and while idle with no start pulse, `outFrameValid` and `outLineValid` are low and both pixel fields are zero.
- R2: A start pulse sampled at a rising edge while the block is idle makes frame-valid and line-valid rise together in the next cycle, carrying the first pixel pair. A start pulse seen during a frame, during a line gap or during a frame gap is ignored.
- R3: Each line holds line-valid high for width/2 consecutive cycles. Cycle k of the line (k from 0) carries pixel 2k in `outPixLo` and pixel 2k+1 in `outPixHi`, with `chanA` feeding the low field and `chanB` the high field. An odd width is rounded up to whole pairs.
- R4: Between two lines of a frame, line-valid is low and frame-valid stays high for exactly `cfgLineBlank` cycles. A value of zero makes lines follow back to back.
- R5: A frame has `cfgFrameHeight` lines. Frame-valid falls in the cycle after the last pair of the last line. It then stays low for max(`cfgFrameBlank`,1) cycles in which a start pulse is ignored. A start pulse is accepted only after that.
- R6: In 10-bit mode (effective mode 0), each pixel field equals its 10-bit source value.
- R7: In 8-bit mode (effective mode 1), each field's bits [7:0] are source bits [9:2] and bits [9:8] are zero.
- R8: The effective mode follows `modeEightBit` only at rising edges where frame-valid is low, so all pairs of one frame use one pixel depth.
- R9: With `testPatternEn` high, pair k of each line carries the values 2k and 2k+1 (modulo 1024) in place of the channel samples, before any depth reduction.
- R10: Both pixel fields are zero in every cycle in which line-valid is low.
- R11: All outputs change only on the falling clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Acquisition finished, begin a frame |
| modeEightBit | input | 1 | 1 selects 8-bit pixel depth, 0 selects 10-bit |
| testPatternEn | input | 1 | Replace channel samples with the counter pattern |
| cfgLineWidth | input | COL_W | Pixels per line (even) |
| cfgFrameHeight | input | ROW_W | Lines per frame (at least 1) |
| cfgLineBlank | input | BLANK_W | Gap cycles between lines |
| cfgFrameBlank | input | BLANK_W | Gap cycles after a frame |
| chanA | input | PIX_W | Sample for the lower-numbered pixel of the pair |
| chanB | input | PIX_W | Sample for the higher-numbered pixel of the pair |
| outFrameValid | output | 1 | Frame-valid flag |
| outLineValid | output | 1 | Line-valid flag |
| outPixLo | output | PIX_W | Lower-numbered pixel of the pair |
| outPixHi | output | PIX_W | Higher-numbered pixel of the pair |

## Verification
The bench builds the block with PIX_W 10, DROP_W 2, COL_W 9, ROW_W 4 and BLANK_W 4. A 9-bit width field admits a 510-pixel line. That line drives the counter pattern above 255, so the 8-bit reduction shows the upper source bits moving into the low byte. The 4-bit gap fields keep zero gaps, single-cycle gaps and multi-cycle gaps cheap to cover. Start pulses are issued during lines, line gaps and the last frame-gap cycle, and the mode input toggles mid-frame, so the ignore rules and the frame-boundary mode rule are all exercised.

// File: rtl/dpf_pkg.sv
package dpf_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ACTIVE = 2'd1,
    SEQ_LBLANK = 2'd2,
    SEQ_FBLANK = 2'd3
  } seq_state_t;

  // Strobes from sequencing control to the output datapath
  typedef struct packed {
    logic frameValid;
    logic lineValid;
    logic firstPair;
    logic eightBit;
  } strobe_t;

endpackage

// File: rtl/dpf_control.sv
module dpf_control
  import dpf_pkg::*;
#(
  parameter int COL_W   = 12,
  parameter int ROW_W   = 12,
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               modeEightBit,
  input  logic [COL_W-1:0]   cfgLineWidth,
  input  logic [ROW_W-1:0]   cfgFrameHeight,
  input  logic [BLANK_W-1:0] cfgLineBlank,
  input  logic [BLANK_W-1:0] cfgFrameBlank,
  output strobe_t            strobe
);

  localparam int PAIR_CMP_W = COL_W + 2;

  seq_state_t         state;
  logic [COL_W-1:0]   colCnt;
  logic [ROW_W-1:0]   rowCnt;
  logic [BLANK_W-1:0] blankCnt;
  logic               modeReg;

  logic lastPair, lastRow, lineGapDone, frameGapDone, inFrame;

  // Pair is last once 2*(col+1) reaches the width (odd widths round up)
  assign lastPair     = ({1'b0, colCnt, 1'b0} + PAIR_CMP_W'(2)) >= {2'b00, cfgLineWidth};
  assign lastRow      = rowCnt == (cfgFrameHeight - ROW_W'(1));
  assign lineGapDone  = blankCnt == (cfgLineBlank - BLANK_W'(1));
  assign frameGapDone = ({1'b0, blankCnt} + (BLANK_W+1)'(1)) >= {1'b0, cfgFrameBlank};
  assign inFrame      = (state == SEQ_ACTIVE) || (state == SEQ_LBLANK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      colCnt   <= '0;
      rowCnt   <= '0;
      blankCnt <= '0;
      modeReg  <= 1'b0;
    end else begin
      if (!inFrame) modeReg <= modeEightBit;
      unique case (state)
        SEQ_IDLE: begin
          if (startPulse) begin
            state  <= SEQ_ACTIVE;
            colCnt <= '0;
            rowCnt <= '0;
          end
        end
        SEQ_ACTIVE: begin
          if (!lastPair) begin
            colCnt <= colCnt + COL_W'(1);
          end else begin
            colCnt   <= '0;
            blankCnt <= '0;
            if (lastRow)                 state  <= SEQ_FBLANK;
            else if (cfgLineBlank == '0) rowCnt <= rowCnt + ROW_W'(1);
            else                         state  <= SEQ_LBLANK;
          end
        end
        SEQ_LBLANK: begin
          if (lineGapDone) begin
            state  <= SEQ_ACTIVE;
            rowCnt <= rowCnt + ROW_W'(1);
          end else begin
            blankCnt <= blankCnt + BLANK_W'(1);
          end
        end
        SEQ_FBLANK: begin
          if (frameGapDone) state    <= SEQ_IDLE;
          else              blankCnt <= blankCnt + BLANK_W'(1);
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign strobe.frameValid = inFrame;
  assign strobe.lineValid  = state == SEQ_ACTIVE;
  assign strobe.firstPair  = (state == SEQ_ACTIVE) && (colCnt == '0);
  assign strobe.eightBit   = modeReg;

  AST_FRAME_OPENS_ON_PAIR_ONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.frameValid) |-> (strobe.lineValid && strobe.firstPair)); // R2

  AST_DEPTH_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    strobe.frameValid |=> $stable(strobe.eightBit)); // R8

  AST_PAIR_INSIDE_LINE: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_ACTIVE) |-> ({1'b0, colCnt, 1'b0} < {2'b00, cfgLineWidth})); // R3

  AST_GAP_KEEPS_FRAME_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_FBLANK) |=> !strobe.frameValid); // R5

endmodule

// File: rtl/dpf_datapath.sv
module dpf_datapath
  import dpf_pkg::*;
#(
  parameter int PIX_W  = 10,
  parameter int DROP_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             testPatternEn,
  input  logic [PIX_W-1:0] chanA,
  input  logic [PIX_W-1:0] chanB,
  output logic             outFrameValid,
  output logic             outLineValid,
  output logic [PIX_W-1:0] outPixLo,
  output logic [PIX_W-1:0] outPixHi
);

  localparam int LANES = 2;
  localparam int KEEP_W = PIX_W - DROP_W;

  logic [PIX_W-1:0] patBase, patNext;
  logic [PIX_W-1:0] rawPix [LANES];
  logic [PIX_W-1:0] srcPix [LANES];
  logic [PIX_W-1:0] fitPix [LANES];

  assign rawPix[0] = chanA;
  assign rawPix[1] = chanB;
  assign patNext   = strobe.firstPair ? '0 : patBase + PIX_W'(2);

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign srcPix[lane] = testPatternEn ? patNext + PIX_W'(lane) : rawPix[lane];
    assign fitPix[lane] = strobe.eightBit
                        ? {{DROP_W{1'b0}}, srcPix[lane][PIX_W-1 -: KEEP_W]}
                        : srcPix[lane];
  end

  // Output word is launched on the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      patBase       <= '0;
      outFrameValid <= 1'b0;
      outLineValid  <= 1'b0;
      outPixLo      <= '0;
      outPixHi      <= '0;
    end else begin
      outFrameValid <= strobe.frameValid;
      outLineValid  <= strobe.lineValid;
      if (strobe.lineValid) begin
        patBase  <= patNext;
        outPixLo <= fitPix[0];
        outPixHi <= fitPix[1];
      end else begin
        outPixLo <= '0;
        outPixHi <= '0;
      end
    end
  end

  AST_IDLE_FIELDS_ZERO: assert property (@(negedge clk) disable iff (!rstN)
    !outLineValid |-> (outPixLo == '0 && outPixHi == '0)); // R10

  AST_NARROW_TOP_ZERO: assert property (@(negedge clk) disable iff (!rstN)
    (strobe.lineValid && strobe.eightBit)
      |=> (outPixLo[PIX_W-1 -: DROP_W] == '0 && outPixHi[PIX_W-1 -: DROP_W] == '0)); // R7

  AST_LINE_NEEDS_FRAME: assert property (@(negedge clk) disable iff (!rstN)
    outLineValid |-> outFrameValid); // R3

endmodule

// File: rtl/dual_pixel_formatter.sv
module dual_pixel_formatter
  import dpf_pkg::*;
#(
  parameter int PIX_W   = 10,
  parameter int DROP_W  = 2,
  parameter int COL_W   = 12,
  parameter int ROW_W   = 12,
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startPulse,
  input  logic               modeEightBit,
  input  logic               testPatternEn,
  input  logic [COL_W-1:0]   cfgLineWidth,
  input  logic [ROW_W-1:0]   cfgFrameHeight,
  input  logic [BLANK_W-1:0] cfgLineBlank,
  input  logic [BLANK_W-1:0] cfgFrameBlank,
  input  logic [PIX_W-1:0]   chanA,
  input  logic [PIX_W-1:0]   chanB,
  output logic               outFrameValid,
  output logic               outLineValid,
  output logic [PIX_W-1:0]   outPixLo,
  output logic [PIX_W-1:0]   outPixHi
);

  strobe_t strobe;

  dpf_control #(
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .BLANK_W(BLANK_W)
  ) i_control (
    .clk           (clk),
    .rstN          (rstN),
    .startPulse    (startPulse),
    .modeEightBit  (modeEightBit),
    .cfgLineWidth  (cfgLineWidth),
    .cfgFrameHeight(cfgFrameHeight),
    .cfgLineBlank  (cfgLineBlank),
    .cfgFrameBlank (cfgFrameBlank),
    .strobe        (strobe)
  );

  dpf_datapath #(
    .PIX_W (PIX_W),
    .DROP_W(DROP_W)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .testPatternEn(testPatternEn),
    .chanA        (chanA),
    .chanB        (chanB),
    .outFrameValid(outFrameValid),
    .outLineValid (outLineValid),
    .outPixLo     (outPixLo),
    .outPixHi     (outPixHi)
  );

endmodule

// File: tb/test_dual_pixel_formatter.sv
`timescale 1ns/1ps
module test_dual_pixel_formatter;

  localparam int PIX_W = 10;
  localparam int DROP_W = 2;
  localparam int COL_W = 9;
  localparam int ROW_W = 4;
  localparam int BLANK_W = 4;
  localparam int PIX_MOD = 1 << PIX_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic drvStart = 1'b0, drvMode = 1'b0, drvTest = 1'b0;
  logic [COL_W-1:0] drvWidth = '0;
  logic [ROW_W-1:0] drvHeight = '0;
  logic [BLANK_W-1:0] drvLineBlank = '0, drvFrameBlank = '0;
  logic [PIX_W-1:0] drvA = '0, drvB = '0;
  logic outFv, outLv;
  logic [PIX_W-1:0] outLo, outHi;

  always #10 clk = ~clk;

  dual_pixel_formatter #(
    .PIX_W(PIX_W), .DROP_W(DROP_W), .COL_W(COL_W), .ROW_W(ROW_W), .BLANK_W(BLANK_W)
  ) i_dual_pixel_formatter (
    .clk(clk), .rstN(rstN), .startPulse(drvStart), .modeEightBit(drvMode),
    .testPatternEn(drvTest), .cfgLineWidth(drvWidth), .cfgFrameHeight(drvHeight),
    .cfgLineBlank(drvLineBlank), .cfgFrameBlank(drvFrameBlank),
    .chanA(drvA), .chanB(drvB),
    .outFrameValid(outFv), .outLineValid(outLv), .outPixLo(outLo), .outPixHi(outHi)
  );

  typedef struct {
    bit fv;
    bit lv;
    bit busy;
    int col;
  } slot_t;

  slot_t plan[$];
  slot_t cur = '{0, 0, 0, 0};
  bit modeEff = 0;
  int checks = 0, fails = 0;
  string reqTag = "R1";
  bit haveSample = 0, done = 0;
  logic sFv, sLv;
  logic [PIX_W-1:0] sLo, sHi;

  task automatic buildFrame();
    int pairs = (int'(drvWidth) + 1) / 2;
    int gapEnd = (drvFrameBlank == 0) ? 1 : int'(drvFrameBlank);
    for (int r = 0; r < int'(drvHeight); r++) begin
      for (int c = 0; c < pairs; c++) plan.push_back('{1, 1, 1, c});
      if (r < int'(drvHeight) - 1)
        for (int b = 0; b < int'(drvLineBlank); b++) plan.push_back('{1, 0, 1, 0});
    end
    for (int b = 0; b < gapEnd; b++) plan.push_back('{0, 0, 1, 0});
  endtask

  function automatic int shapePix(input int v);
    return modeEff ? (v % PIX_MOD) >> DROP_W : v % PIX_MOD;
  endfunction

  task automatic tick(input bit st, input bit onlyBusy);
    int expLo, expHi;
    @(posedge clk);
    if (rstN) begin
      if (!cur.fv) modeEff = drvMode;
      if (!cur.busy && plan.size() == 0 && drvStart) buildFrame();
      if (plan.size() > 0) cur = plan.pop_front();
      else cur = '{0, 0, 0, 0};
    end else begin
      modeEff = 0;
      cur = '{0, 0, 0, 0};
    end
    #1;
    if (haveSample) begin
      checks++;
      if (outFv !== sFv || outLv !== sLv || outLo !== sLo || outHi !== sHi) begin
        fails++;
        $display("FAIL R11: outputs moved at rising edge, actual %b %b %h %h expected %b %b %h %h",
                 outFv, outLv, outLo, outHi, sFv, sLv, sLo, sHi);
      end
    end
    drvStart = st && (!onlyBusy || cur.busy);
    drvA = PIX_W'($urandom);
    drvB = PIX_W'($urandom);
    @(negedge clk);
    #1;
    if (cur.lv) begin
      expLo = shapePix(drvTest ? 2 * cur.col : int'(drvA));
      expHi = shapePix(drvTest ? 2 * cur.col + 1 : int'(drvB));
    end else begin
      expLo = 0;
      expHi = 0;
    end
    checks++;
    if (outFv !== cur.fv || outLv !== cur.lv || int'(outLo) != expLo || int'(outHi) != expHi) begin
      fails++;
      $display("FAIL %s: fv lv lo hi actual %b %b %h %h expected %b %b %h %h",
               reqTag, outFv, outLv, outLo, outHi, cur.fv, cur.lv, expLo, expHi);
    end
    sFv = outFv; sLv = outLv; sLo = outLo; sHi = outHi;
    haveSample = 1;
  endtask

  task automatic runFrame(input int w, input int h, input int lb, input int fb,
                          input bit harass, input bit toggle);
    int n = 0;
    drvWidth = COL_W'(w);
    drvHeight = ROW_W'(h);
    drvLineBlank = BLANK_W'(lb);
    drvFrameBlank = BLANK_W'(fb);
    tick(1, 0);
    do begin
      if (toggle && (n % 3 == 1)) drvMode = ~drvMode;
      tick(harass, 1);
      n++;
    end while (cur.busy);
    tick(0, 0);
    tick(0, 0);
  endtask

  initial begin
    // R1: reset and idle outputs
    reqTag = "R1";
    for (int i = 0; i < 3; i++) tick(0, 0);
    rstN = 1'b1;
    for (int i = 0; i < 3; i++) tick(0, 0);

    // R2 R3 R4 R5 R6 R10: 10-bit frames, starts issued while busy
    reqTag = "R2 R3 R4 R5 R6 R10";
    drvMode = 0;
    runFrame(6, 3, 2, 3, 1, 0);
    runFrame(4, 2, 1, 0, 1, 0);
    runFrame(5, 2, 1, 1, 0, 0);

    // R4 R7 R8: 8-bit depth, back-to-back lines, mode toggled mid-frame
    reqTag = "R4 R7 R8";
    drvMode = 1;
    runFrame(8, 3, 0, 2, 1, 1);
    drvMode = 1;
    runFrame(6, 4, 3, 1, 0, 1);

    // R9: counter pattern, wide line reaching values above 255
    reqTag = "R9";
    drvTest = 1;
    drvMode = 0;
    runFrame(510, 2, 1, 1, 0, 0);
    drvMode = 1;
    runFrame(510, 2, 0, 2, 0, 0);
    reqTag = "R5 R9";
    runFrame(2, 1, 0, 0, 1, 0);
    drvTest = 0;

    reqTag = "R1";
    for (int i = 0; i < 4; i++) tick(0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule